// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block sits between the external pins of a parallel NOR flash model and its internal command and array logic. It turns the chip-select, output-enable, write-enable and hardware-reset strobes into one bus operation per clock: read, write, output disable, standby, conflicting strobes, or reset. It also decides which data pins are driven. In wide mode all sixteen data pins carry data. In narrow mode only the low byte is driven, and the top data pin becomes the least significant address bit.

Writes are qualified before they reach the command logic. A strobe must be held for a minimum number of clock cycles. A write that is already present when the model powers up is refused, and no write is accepted while the low-supply lockout input is high. The address and data of a qualified write are handed downstream with a one-cycle valid pulse once the strobes release. A registered ready output reports a stand-in embedded operation. When the hardware reset pin falls, ready is held low for a recovery time that is longer when an operation was running.

All pins are modelled as synchronous digital inputs. Addresses are expressed in bytes, AW+1 bits wide; in wide mode the lowest bit is zero.

Top module: `flash_bus_front`

## Requirements
- R1: With chip select low, output enable low, write enable high and reset high in wide mode, the block requests a read at byte address {addr,0}, drives all 16 data pins, and passes the array word through unchanged.
- R2: With chip select high (standby) or with both enables high (output disable), the block drives no data pin and requests no read.
- R3: In narrow mode a read drives only pins 7..0. Data pin 15 is taken as the address LSB, so the read address is {addr, dq_in[15]}. The array's upper byte is returned when that bit is 1 and the lower byte when it is 0. Pins 15..8 are never driven in this mode.
- R4: A write strobe held for at least MIN_PULSE clock edges and then released by raising chip select or write enable (output enable still high) produces cmd_valid for exactly one cycle, starting at the edge that samples the release. In wide mode cmd_wide=1, cmd_addr={addr,0} and cmd_data=dq_in.
- R5: A write strobe held for fewer than MIN_PULSE edges produces no cmd_valid.
- R6: If output enable goes low while a write is asserted, the write is abandoned and produces no cmd_valid.
- R7: A write combination already present when the power-up reset (rst_n) is released is ignored until the strobes have left that combination once.
- R8: While supply_low is 1, no write produces cmd_valid. After the lockout clears, the next write is accepted once the strobes have left the write combination.
- R9: While hw_reset_n is 0, no data pin is driven, no read is requested, and a write in progress is discarded.
- R10: If hw_reset_n falls while an embedded operation is busy, ready stays 0 for REC_BUSY edges after the edge that samples the fall, and then returns to 1, whatever the pin does meanwhile.
- R11: If hw_reset_n falls while no operation is busy, ready is 0 for REC_IDLE edges and then returns to 1.
- R12: ready is 1 after power-up. It goes to 0 on the edge after emb_start is sampled with hw_reset_n high, and returns to 1 on the edge that samples emb_done.
- R13: A qualified write in narrow mode gives cmd_wide=0, cmd_addr={addr, dq_in[15]} and cmd_data={8'h00, dq_in[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| hw_reset_n | input | 1 | Hardware reset pin, active low |
| narrow_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| supply_low | input | 1 | Low-supply lockout |
| addr | input | AW | Word address pins |
| dq_in | input | 16 | Data pins as seen by the device |
| array_rdata | input | 16 | Word returned by the array for rd_addr |
| emb_start | input | 1 | Start of a stand-in embedded operation |
| emb_done | input | 1 | End of the embedded operation |
| rd_en | output | 1 | Read request to the array |
| rd_addr | output | AW+1 | Byte address of the read |
| dq_out | output | 16 | Data driven onto the pins |
| dq_oe_lo | output | 1 | Drive enable for pins 7..0 |
| dq_oe_hi | output | 1 | Drive enable for pins 15..8 |
| cmd_valid | output | 1 | One-cycle pulse for a qualified write |
| cmd_addr | output | AW+1 | Byte address of the write |
| cmd_data | output | 16 | Data of the write |
| cmd_wide | output | 1 | 1 if the write was word-wide |
| ready | output | 1 | Registered ready (1) / busy (0) |

## Verification
The assertions assume that every pin is already synchronous to clk and is sampled once per edge. They also assume that REC_IDLE is at least one, and that emb_start and emb_done never arrive while hw_reset_n is low. The bench drives every input one nanosecond after a rising edge and holds it until the next edge, so no pin changes near a sampling point. It raises the embedded-operation strobes only while the reset pin is high.

// File: rtl/flash_fe_pkg.sv
// Shared types for the flash bus front end.
package flash_fe_pkg;
    // One bus operation per clock, decoded from the strobes.
    typedef enum logic [2:0] {
        OP_RESET,
        OP_STANDBY,
        OP_READ,
        OP_WRITE,
        OP_OUTDIS,
        OP_CONFLICT
    } bus_op_e;
endpackage

// File: rtl/strobe_decode.sv
// Decodes the strobe pins into one bus operation.
// Assumes: the pins are synchronous. The reset pin has priority over
// everything, and chip select over the two enables.
module strobe_decode
    import flash_fe_pkg::*;
(
    input  logic    chip_sel_n,
    input  logic    out_en_n,
    input  logic    wr_en_n,
    input  logic    hw_reset_n,
    output bus_op_e op
);
    // Priority decode of the strobe combination.
    always_comb begin
        if (!hw_reset_n)                 op = OP_RESET;
        else if (chip_sel_n)             op = OP_STANDBY;
        else if (!out_en_n && wr_en_n)   op = OP_READ;
        else if (out_en_n && !wr_en_n)   op = OP_WRITE;
        else if (out_en_n && wr_en_n)    op = OP_OUTDIS;
        else                             op = OP_CONFLICT;
    end
endmodule

// File: rtl/write_qual.sv
// Qualifies write strobes and issues one command per good write.
// Behaviour:
// - A write must be held for MIN_PULSE edges before it can count.
// - A write already present at power-up is locked out, and so is any
//   write while the lockout input is high.
// - Address and data are held from the last asserted cycle and are
//   released as a one-cycle pulse when the write ends cleanly.
// Assumes: MIN_PULSE >= 1.
module write_qual
    import flash_fe_pkg::*;
#(
    parameter int AW        = 18,
    parameter int MIN_PULSE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_op_e       op,
    input  logic          supply_low,
    input  logic          narrow_mode,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic          cmd_valid,
    output logic [AW:0]   cmd_addr,
    output logic [15:0]   cmd_data,
    output logic          cmd_wide
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    logic          lock;
    logic [CW-1:0] cnt;
    logic          wr_on;
    logic          clean_end;

    assign wr_on     = (op == OP_WRITE) && !lock && !supply_low;
    assign clean_end = (cnt == CW'(MIN_PULSE)) && !supply_low &&
                       ((op == OP_STANDBY) || (op == OP_OUTDIS));

    // Power-up and lockout guard: it clears once the strobes leave the write combination.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_low) lock <= 1'b1;
        else if (op != OP_WRITE)  lock <= 1'b0;
    end

    // Pulse-width counter, saturating at MIN_PULSE.
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_on)           cnt <= '0;
        else if (cnt != CW'(MIN_PULSE)) cnt <= cnt + CW'(1);
    end

    // Hold the address and data of the latest asserted write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_data <= '0;
            cmd_wide <= 1'b1;
        end else if (wr_on) begin
            cmd_addr <= narrow_mode ? {addr, dq_in[15]} : {addr, 1'b0};
            cmd_data <= narrow_mode ? {8'h00, dq_in[7:0]} : dq_in;
            cmd_wide <= !narrow_mode;
        end
    end

    // One-cycle command pulse when a qualified write ends cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_valid <= 1'b0;
        else        cmd_valid <= clean_end;
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r8_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !cmd_valid);
    a_r9_reset_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESET) |=> !cmd_valid);
    a_r6_conflict_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CONFLICT) |=> !cmd_valid);
endmodule

// File: rtl/reset_seq.sv
// Tracks the busy flag of the stand-in embedded operation and runs the
// recovery interval after a hardware reset.
// Assumes: REC_IDLE >= 1 and REC_BUSY >= 1. The operation strobes only
// arrive while the reset pin is high.
module reset_seq #(
    parameter int REC_BUSY = 20,
    parameter int REC_IDLE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_reset_n,
    input  logic emb_start,
    input  logic emb_done,
    output logic ready
);
    localparam int RMAX = (REC_BUSY > REC_IDLE) ? REC_BUSY : REC_IDLE;
    localparam int RW   = $clog2(RMAX + 1);

    logic          busy, busy_n;
    logic          hw_q;
    logic [RW-1:0] rec, rec_n;

    // Next-state logic: a falling pin loads the recovery count; otherwise count down and track busy.
    always_comb begin
        busy_n = busy;
        rec_n  = rec;
        if (!hw_reset_n && hw_q) begin
            rec_n  = busy ? RW'(REC_BUSY) : RW'(REC_IDLE);
            busy_n = 1'b0;
        end else begin
            if (rec != '0) rec_n = rec - RW'(1);
            if (hw_reset_n) begin
                if (emb_done)  busy_n = 1'b0;
                if (emb_start) busy_n = 1'b1;
            end
        end
    end

    // State registers and the registered ready output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            rec   <= '0;
            hw_q  <= 1'b1;
            ready <= 1'b1;
        end else begin
            busy  <= busy_n;
            rec   <= rec_n;
            hw_q  <= hw_reset_n;
            ready <= !busy_n && (rec_n == '0);
        end
    end

    a_r12_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (emb_start && hw_reset_n) |=> !ready);
    a_r10_fall_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_reset_n && hw_q) |=> !ready);
    a_r11_recovery_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (rec == RW'(1) && hw_reset_n && !busy && !emb_start) |=> ready);
endmodule

// File: rtl/flash_bus_front.sv
// Top of the flash bus front end. It wires the strobe decoder, the write
// qualifier and the reset sequencer together, and holds the read-path
// muxing for word and byte modes.
// Assumes: all pins are synchronous to clk.
module flash_bus_front
    import flash_fe_pkg::*;
#(
    parameter int AW        = 18,
    parameter int MIN_PULSE = 3,
    parameter int REC_BUSY  = 20,
    parameter int REC_IDLE  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_sel_n,
    input  logic          out_en_n,
    input  logic          wr_en_n,
    input  logic          hw_reset_n,
    input  logic          narrow_mode,
    input  logic          supply_low,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    input  logic [15:0]   array_rdata,
    input  logic          emb_start,
    input  logic          emb_done,
    output logic          rd_en,
    output logic [AW:0]   rd_addr,
    output logic [15:0]   dq_out,
    output logic          dq_oe_lo,
    output logic          dq_oe_hi,
    output logic          cmd_valid,
    output logic [AW:0]   cmd_addr,
    output logic [15:0]   cmd_data,
    output logic          cmd_wide,
    output logic          ready
);
    bus_op_e op;

    strobe_decode u_dec (
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .wr_en_n    (wr_en_n),
        .hw_reset_n (hw_reset_n),
        .op         (op)
    );

    write_qual #(.AW(AW), .MIN_PULSE(MIN_PULSE)) u_wq (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .supply_low  (supply_low),
        .narrow_mode (narrow_mode),
        .addr        (addr),
        .dq_in       (dq_in),
        .cmd_valid   (cmd_valid),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data),
        .cmd_wide    (cmd_wide)
    );

    reset_seq #(.REC_BUSY(REC_BUSY), .REC_IDLE(REC_IDLE)) u_rs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_reset_n (hw_reset_n),
        .emb_start  (emb_start),
        .emb_done   (emb_done),
        .ready      (ready)
    );

    // Read request and address: in byte mode pin 15 supplies the address LSB.
    always_comb begin
        rd_en   = (op == OP_READ);
        rd_addr = narrow_mode ? {addr, dq_in[15]} : {addr, 1'b0};
    end

    // Output data and drive enables for the two halves of the bus.
    always_comb begin
        dq_oe_lo = (op == OP_READ);
        dq_oe_hi = (op == OP_READ) && !narrow_mode;
        if (narrow_mode)
            dq_out = {8'h00, dq_in[15] ? array_rdata[15:8] : array_rdata[7:0]};
        else
            dq_out = array_rdata;
    end

    a_r9_reset_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_reset_n |-> (!dq_oe_lo && !dq_oe_hi && !rd_en));
    a_r3_high_half_wide_only: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_hi |-> (dq_oe_lo && !narrow_mode));
    a_r2_standby_floats: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |-> (!dq_oe_lo && !rd_en));
endmodule

// File: tb/flash_bus_front_tb.sv
`timescale 1ns/1ps
module flash_bus_front_tb;
    localparam int AW = 18;
    localparam int MP = 3;
    localparam int RB = 20;
    localparam int RI = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b0, out_en_n = 1'b1, wr_en_n = 1'b0;
    logic          hw_reset_n = 1'b1, narrow_mode = 1'b0, supply_low = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0, array_rdata = '0;
    logic          emb_start = 1'b0, emb_done = 1'b0;
    logic          rd_en, dq_oe_lo, dq_oe_hi, cmd_valid, cmd_wide, ready;
    logic [AW:0]   rd_addr, cmd_addr;
    logic [15:0]   dq_out, cmd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_bus_front #(.AW(AW), .MIN_PULSE(MP), .REC_BUSY(RB), .REC_IDLE(RI)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
        .wr_en_n(wr_en_n), .hw_reset_n(hw_reset_n), .narrow_mode(narrow_mode),
        .supply_low(supply_low), .addr(addr), .dq_in(dq_in), .array_rdata(array_rdata),
        .emb_start(emb_start), .emb_done(emb_done), .rd_en(rd_en), .rd_addr(rd_addr),
        .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_wide(cmd_wide), .ready(ready)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        chip_sel_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
    endtask

    // Write held for len edges, then released by raising write enable.
    task automatic run_write(input logic [AW-1:0] a, input logic [15:0] d,
                             input logic nar, input int len, output logic got);
        addr = a; dq_in = d; narrow_mode = nar;
        chip_sel_n = 1'b0; out_en_n = 1'b1; wr_en_n = 1'b0;
        repeat (len) tick();
        wr_en_n = 1'b1;
        tick();
        got = cmd_valid;
    endtask

    task automatic t_reset_state();
        chk("R12 ready after power-up", ready, 1);
        chk("R4 no command after power-up", cmd_valid, 0);
        chk("R9 no drive in reset state", dq_oe_lo, 0);
    endtask

    task automatic t_powerup_lock();
        logic got;
        repeat (MP + 2) tick();
        wr_en_n = 1'b1;
        tick();
        got = cmd_valid;
        chk("R7 write present at power-up ignored", got, 0);
        tick();
        chk("R7 still no command", cmd_valid, 0);
        idle_bus();
        tick();
    endtask

    task automatic t_read_word();
        idle_bus(); narrow_mode = 0; addr = 18'h1234; array_rdata = 16'hA55A;
        chip_sel_n = 0; out_en_n = 0;
        tick();
        chk("R1 read request", rd_en, 1);
        chk("R1 read address", rd_addr, {18'h1234, 1'b0});
        chk("R1 word data", dq_out, 16'hA55A);
        chk("R1 both halves driven", {dq_oe_hi, dq_oe_lo}, 2'b11);
        idle_bus();
    endtask

    task automatic t_read_byte();
        idle_bus(); narrow_mode = 1; addr = 18'h0F0F; array_rdata = 16'hA55A;
        dq_in = 16'h8000; chip_sel_n = 0; out_en_n = 0;
        tick();
        chk("R3 upper byte when LSB=1", dq_out, 16'h00A5);
        chk("R3 address LSB from pin 15", rd_addr, {18'h0F0F, 1'b1});
        chk("R3 only low half driven", {dq_oe_hi, dq_oe_lo}, 2'b01);
        dq_in = 16'h0000;
        tick();
        chk("R3 lower byte when LSB=0", dq_out, 16'h005A);
        idle_bus(); narrow_mode = 0;
    endtask

    task automatic t_no_drive();
        idle_bus(); chip_sel_n = 0;
        tick();
        chk("R2 output disable floats", {dq_oe_hi, dq_oe_lo, rd_en}, 3'b000);
        chip_sel_n = 1; out_en_n = 0;
        tick();
        chk("R2 standby floats", {dq_oe_hi, dq_oe_lo, rd_en}, 3'b000);
        idle_bus();
    endtask

    task automatic t_write_word();
        logic got;
        run_write(18'h2AAAA, 16'hBEEF, 1'b0, MP, got);
        chk("R4 command pulse", got, 1);
        chk("R4 command address", cmd_addr, {18'h2AAAA, 1'b0});
        chk("R4 command data", cmd_data, 16'hBEEF);
        chk("R4 word flag", cmd_wide, 1);
        tick();
        chk("R4 pulse lasts one cycle", cmd_valid, 0);
        idle_bus();
    endtask

    task automatic t_write_byte();
        logic got;
        run_write(18'h00155, 16'h8034, 1'b1, MP + 1, got);
        chk("R13 byte command pulse", got, 1);
        chk("R13 byte address LSB", cmd_addr, {18'h00155, 1'b1});
        chk("R13 byte data", cmd_data, 16'h0034);
        chk("R13 byte flag", cmd_wide, 0);
        idle_bus(); narrow_mode = 0;
        tick();
    endtask

    task automatic t_glitch();
        logic got;
        run_write(18'h3, 16'h1111, 1'b0, MP - 1, got);
        chk("R5 short strobe rejected", got, 0);
        tick();
        chk("R5 still no command", cmd_valid, 0);
        idle_bus();
    endtask

    task automatic t_conflict();
        addr = 18'h5; dq_in = 16'h2222;
        chip_sel_n = 0; out_en_n = 1; wr_en_n = 0;
        repeat (MP + 1) tick();
        out_en_n = 0;
        tick();
        chk("R6 no command on conflict", cmd_valid, 0);
        idle_bus();
        tick();
        chk("R6 no command after release", cmd_valid, 0);
    endtask

    task automatic t_supply_low();
        logic got;
        supply_low = 1;
        run_write(18'h7, 16'h3333, 1'b0, MP + 2, got);
        chk("R8 write ignored under lockout", got, 0);
        idle_bus(); supply_low = 0;
        tick();
        run_write(18'h8, 16'h4444, 1'b0, MP, got);
        chk("R8 write accepted after lockout clears", got, 1);
        idle_bus();
        tick();
    endtask

    task automatic t_hw_reset_idle();
        logic got;
        addr = 18'h9; dq_in = 16'h5555;
        chip_sel_n = 0; out_en_n = 1; wr_en_n = 0;
        repeat (MP + 1) tick();
        hw_reset_n = 0; out_en_n = 0; wr_en_n = 1;
        #1;
        chk("R9 reads ignored, pins float", {dq_oe_hi, dq_oe_lo, rd_en}, 3'b000);
        tick();
        chk("R11 ready low after idle reset", ready, 0);
        tick();
        chk("R11 ready low during short recovery", ready, 0);
        tick();
        chk("R11 ready back after short recovery", ready, 1);
        idle_bus(); hw_reset_n = 1;
        tick();
        got = cmd_valid;
        chk("R9 write in progress discarded", got, 0);
    endtask

    task automatic t_busy_flag();
        emb_start = 1;
        tick();
        emb_start = 0;
        chk("R12 busy after start", ready, 0);
        repeat (4) tick();
        chk("R12 busy holds", ready, 0);
        emb_done = 1;
        tick();
        emb_done = 0;
        chk("R12 ready after done", ready, 1);
    endtask

    task automatic t_hw_reset_busy();
        emb_start = 1;
        tick();
        emb_start = 0;
        hw_reset_n = 0;
        tick();
        chk("R10 ready low at reset during operation", ready, 0);
        for (int i = 1; i < RB; i++) begin
            if (i == 3) hw_reset_n = 1;
            tick();
        end
        chk("R10 ready low at end of long recovery", ready, 0);
        tick();
        chk("R10 ready back after long recovery", ready, 1);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        #1;
        t_reset_state();
        t_powerup_lock();
        t_read_word();
        t_read_byte();
        t_no_drive();
        t_write_word();
        t_write_byte();
        t_glitch();
        t_conflict();
        t_supply_low();
        t_hw_reset_idle();
        t_busy_flag();
        t_hw_reset_busy();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule